// File: doc/BRIEF.md
# Per-Bit Program Time Measurement Engine

This block measures how many aborted program pulses each cell of a flash page needs before it reads as programmed. After a start request it clears its own time store, erases the target block and reads the page once. It then repeats a cycle: issue a program-all-zeros command, cut it off with an abort command after a programmable number of clocks, wait for the device to settle, and read the page back. A bit seen at 0 for the first time takes the current pulse number as its program time, and that value is frozen from then on.

The run ends after the requested number of pulses. The engine then streams one program time per page bit, in ascending bit order. Bits that never flipped carry the all-ones value, which marks them as not programmed. The stream feeds later statistics, such as a median or group averages, that sit outside this block. The device command path is a plain command strobe with a completion pulse. Read data comes back as a sequence of page words.

Top module: `bit_ptime_engine`

## Requirements
- R1: After reset `busy`, `fl_cmd_valid` and `out_valid` are 0.
- R2: A `start` pulse while idle latches `pulse_max`, `abort_dly` and `page_addr`. The first command is erase (code 0) with `fl_addr` equal to the latched address, and every later command carries the same address. A `start` while `busy` is ignored.
- R3: After the erase completion pulse the engine issues one read (code 3). Any bit that reads 0 in this read gets program time 0.
- R4: Each partial program is a program command (code 1) followed exactly `abort_dly`+1 clocks later by an abort command (code 2). After the abort's completion pulse comes a read.
- R5: A bit first seen at 0 in the read after pulse k gets time k. Later reads never change it, even if the bit reads 1 again.
- R6: A run issues exactly min(`pulse_max`, 2^CNT_W-2) program commands.
- R7: A bit that has not read 0 after the last pulse is reported with time 2^CNT_W-1.
- R8: After the last read, exactly PAGE_BITS beats leave on `out_valid`, with `out_bit` counting 0 upward. `out_last` marks the final beat, and `busy` then returns to 0.
- R9: Each read takes PAGE_BITS/WORD_W words on `fl_rd_valid`, in order. Bit l of word w is page bit w*WORD_W+l.
- R10: With `pulse_max` 0 the run is one erase and one read, with no program or abort command. Each bit is then reported as 0 or 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a measurement run |
| pulse_max | input | CNT_W | Number of partial programs |
| abort_dly | input | DLY_W | Clocks between program and abort, minus one |
| page_addr | input | ADDR_W | Page to measure |
| busy | output | 1 | Run in progress |
| fl_cmd_valid | output | 1 | One-cycle command strobe to the device |
| fl_cmd | output | 2 | 0 erase, 1 program zeros, 2 abort, 3 read |
| fl_addr | output | ADDR_W | Address sent with each command |
| fl_done | input | 1 | Erase or abort completion pulse |
| fl_rd_valid | input | 1 | Read word strobe |
| fl_rd_data | input | WORD_W | Read word |
| out_valid | output | 1 | Program time beat |
| out_bit | output | $clog2(PAGE_BITS) | Page bit index of the beat |
| out_time | output | CNT_W | Program time of that bit |
| out_last | output | 1 | Final beat of the run |

## Verification
The bench builds the engine with PAGE_BITS=32, WORD_W=8 and CNT_W=4. A read is then four words, and the not-flipped value 15 and the pulse clamp at 14 can both be reached in runs of a few hundred clocks. A device model gives each bit a threshold pulse count and can make chosen bits bounce back to 1 once. Thresholds above the pulse count, at zero, and at the clamp edge all show up in both the directed and the random runs, with abort delays from 0 upward.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef enum logic [1:0] {
    CMD_ERASE   = 2'd0,
    CMD_PROGRAM = 2'd1,
    CMD_ABORT   = 2'd2,
    CMD_READ    = 2'd3
  } fl_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_ERASE, S_READ, S_HOLD, S_ABORT, S_OUT
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_ADDR, PH_LOAD, PH_SHIFT
  } ser_ph_e;
endpackage

// File: rtl/bpt_ram.sv
module bpt_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bpt_seq.sv
module bpt_seq
  import bpt_pkg::*;
#(
  parameter int NWORDS = 16,
  parameter int CNT_W  = 8,
  parameter int DLY_W  = 16,
  parameter int ADDR_W = 20,
  localparam int WIDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  m_in,
  input  logic [DLY_W-1:0]  d_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              fl_done,
  input  logic              last_wr,
  input  logic              ser_done,
  output logic              busy,
  output logic              cmd_valid,
  output logic [1:0]        cmd,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  idx_q,
  output logic              init_we,
  output logic [WIDX_W-1:0] init_addr,
  output logic              rd_en,
  output logic              out_phase,
  output logic              ser_start
);
  localparam logic [CNT_W-1:0] SENT = {CNT_W{1'b1}};
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(NWORDS - 1);

  seq_state_e          state;
  logic [CNT_W-1:0]    m_q;
  logic [DLY_W-1:0]    d_q;
  logic [DLY_W-1:0]    dly;
  logic [WIDX_W-1:0]   init_cnt;
  logic [CNT_W-1:0]    m_eff;

  assign m_eff     = (m_in == SENT) ? SENT - 1'b1 : m_in;
  assign init_we   = (state == S_INIT);
  assign init_addr = init_cnt;
  assign rd_en     = (state == S_READ);
  assign out_phase = (state == S_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd       <= 2'd0;
      addr_q    <= '0;
      m_q       <= '0;
      d_q       <= '0;
      idx_q     <= '0;
      dly       <= '0;
      init_cnt  <= '0;
      ser_start <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      ser_start <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          m_q      <= m_eff;
          d_q      <= d_in;
          addr_q   <= addr_in;
          idx_q    <= '0;
          init_cnt <= '0;
          busy     <= 1'b1;
          state    <= S_INIT;
        end
        S_INIT: begin
          if (init_cnt == LAST_W) begin
            cmd_valid <= 1'b1;
            cmd       <= CMD_ERASE;
            state     <= S_ERASE;
          end else begin
            init_cnt <= init_cnt + 1'b1;
          end
        end
        S_ERASE: if (fl_done) begin
          cmd_valid <= 1'b1;
          cmd       <= CMD_READ;
          state     <= S_READ;
        end
        S_READ: if (last_wr) begin
          if (idx_q == m_q) begin
            ser_start <= 1'b1;
            state     <= S_OUT;
          end else begin
            idx_q     <= idx_q + 1'b1;
            dly       <= '0;
            cmd_valid <= 1'b1;
            cmd       <= CMD_PROGRAM;
            state     <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (dly == d_q) begin
            cmd_valid <= 1'b1;
            cmd       <= CMD_ABORT;
            state     <= S_ABORT;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        S_ABORT: if (fl_done) begin
          cmd_valid <= 1'b1;
          cmd       <= CMD_READ;
          state     <= S_READ;
        end
        S_OUT: if (ser_done) begin
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  idx_le_m_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx_q <= m_q));

  // R4
  abort_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_PROGRAM && d_q == '0) |=> (cmd_valid && cmd == CMD_ABORT));

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(addr_q) && $stable(m_q)));
endmodule

// File: rtl/bpt_update.sv
module bpt_update #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8,
  parameter int NWORDS = 16,
  localparam int WIDX_W = $clog2(NWORDS),
  localparam int DW     = WORD_W * CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cur_idx,
  input  logic [DW-1:0]     ram_rdata,
  output logic [WIDX_W-1:0] ram_raddr,
  output logic              ram_we,
  output logic [WIDX_W-1:0] ram_waddr,
  output logic [DW-1:0]     ram_wdata,
  output logic              last_wr
);
  localparam logic [CNT_W-1:0] SENT = {CNT_W{1'b1}};

  logic [WIDX_W-1:0] rx_cnt;
  logic [WIDX_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cnt <= '0;
      addr_q <= '0;
      data_q <= '0;
      v_q    <= 1'b0;
    end else begin
      v_q <= en && rd_valid;
      if (!en) begin
        rx_cnt <= '0;
      end else if (rd_valid) begin
        rx_cnt <= rx_cnt + 1'b1;
        data_q <= rd_data;
        addr_q <= rx_cnt;
      end
    end
  end

  assign ram_raddr = rx_cnt;
  assign ram_we    = v_q;
  assign ram_waddr = addr_q;
  assign last_wr   = v_q && (addr_q == WIDX_W'(NWORDS - 1));

  for (genvar l = 0; l < WORD_W; l++) begin : g_lane
    logic [CNT_W-1:0] old_t;
    assign old_t = ram_rdata[l*CNT_W +: CNT_W];
    assign ram_wdata[l*CNT_W +: CNT_W] =
      (old_t == SENT && !data_q[l]) ? cur_idx : old_t;

    // R5
    lane_range_chk: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> (ram_wdata[l*CNT_W +: CNT_W] == SENT ||
                  ram_wdata[l*CNT_W +: CNT_W] <= cur_idx));
  end
endmodule

// File: rtl/bpt_ser.sv
module bpt_ser
  import bpt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8,
  parameter int NWORDS = 16,
  localparam int WIDX_W    = $clog2(NWORDS),
  localparam int LANE_W    = $clog2(WORD_W),
  localparam int PAGE_BITS = WORD_W * NWORDS,
  localparam int BIDX_W    = $clog2(PAGE_BITS),
  localparam int DW        = WORD_W * CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DW-1:0]     ram_rdata,
  output logic [WIDX_W-1:0] raddr,
  output logic              out_valid,
  output logic [BIDX_W-1:0] out_bit,
  output logic [CNT_W-1:0]  out_time,
  output logic              out_last,
  output logic              done
);
  ser_ph_e           ph;
  logic [WIDX_W-1:0] word_q;
  logic [LANE_W-1:0] lane_q;
  logic [DW-1:0]     sh;

  assign raddr = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      word_q    <= '0;
      lane_q    <= '0;
      sh        <= '0;
      out_valid <= 1'b0;
      out_bit   <= '0;
      out_time  <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          word_q <= '0;
          ph     <= PH_ADDR;
        end
        PH_ADDR: ph <= PH_LOAD;
        PH_LOAD: begin
          sh     <= ram_rdata;
          lane_q <= '0;
          ph     <= PH_SHIFT;
        end
        PH_SHIFT: begin
          out_valid <= 1'b1;
          out_time  <= sh[CNT_W-1:0];
          out_bit   <= BIDX_W'(int'(word_q) * WORD_W + int'(lane_q));
          sh        <= sh >> CNT_W;
          lane_q    <= lane_q + 1'b1;
          if (lane_q == LANE_W'(WORD_W - 1)) begin
            if (word_q == WIDX_W'(NWORDS - 1)) begin
              out_last <= 1'b1;
              done     <= 1'b1;
              ph       <= PH_IDLE;
            end else begin
              word_q <= word_q + 1'b1;
              ph     <= PH_ADDR;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R8
  last_idx_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_valid && out_bit == BIDX_W'(PAGE_BITS - 1)));
endmodule

// File: rtl/bit_ptime_engine.sv
module bit_ptime_engine #(
  parameter int PAGE_BITS = 256,
  parameter int WORD_W    = 16,
  parameter int CNT_W     = 8,
  parameter int DLY_W     = 16,
  parameter int ADDR_W    = 20,
  localparam int NWORDS   = PAGE_BITS / WORD_W,
  localparam int WIDX_W   = $clog2(NWORDS),
  localparam int BIDX_W   = $clog2(PAGE_BITS),
  localparam int DW       = WORD_W * CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  pulse_max,
  input  logic [DLY_W-1:0]  abort_dly,
  input  logic [ADDR_W-1:0] page_addr,
  output logic              busy,
  output logic              fl_cmd_valid,
  output logic [1:0]        fl_cmd,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic              fl_done,
  input  logic              fl_rd_valid,
  input  logic [WORD_W-1:0] fl_rd_data,
  output logic              out_valid,
  output logic [BIDX_W-1:0] out_bit,
  output logic [CNT_W-1:0]  out_time,
  output logic              out_last
);
  logic [CNT_W-1:0]  idx;
  logic              init_we, rd_en, out_phase, ser_start, ser_done, last_wr;
  logic [WIDX_W-1:0] init_addr, upd_raddr, upd_waddr, ser_raddr;
  logic              upd_we;
  logic [DW-1:0]     upd_wdata, ram_rdata;
  logic              ram_we;
  logic [WIDX_W-1:0] ram_waddr, ram_raddr;
  logic [DW-1:0]     ram_wdata;

  bpt_seq #(.NWORDS(NWORDS), .CNT_W(CNT_W), .DLY_W(DLY_W), .ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst(rst), .start(start), .m_in(pulse_max), .d_in(abort_dly),
    .addr_in(page_addr), .fl_done(fl_done), .last_wr(last_wr), .ser_done(ser_done),
    .busy(busy), .cmd_valid(fl_cmd_valid), .cmd(fl_cmd), .addr_q(fl_addr),
    .idx_q(idx), .init_we(init_we), .init_addr(init_addr), .rd_en(rd_en),
    .out_phase(out_phase), .ser_start(ser_start)
  );

  bpt_update #(.WORD_W(WORD_W), .CNT_W(CNT_W), .NWORDS(NWORDS)) upd_i (
    .clk(clk), .rst(rst), .en(rd_en), .rd_valid(fl_rd_valid), .rd_data(fl_rd_data),
    .cur_idx(idx), .ram_rdata(ram_rdata), .ram_raddr(upd_raddr), .ram_we(upd_we),
    .ram_waddr(upd_waddr), .ram_wdata(upd_wdata), .last_wr(last_wr)
  );

  assign ram_we    = init_we | upd_we;
  assign ram_waddr = init_we ? init_addr : upd_waddr;
  assign ram_wdata = init_we ? {DW{1'b1}} : upd_wdata;
  assign ram_raddr = out_phase ? ser_raddr : upd_raddr;

  bpt_ram #(.DEPTH(NWORDS), .DW(DW)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  bpt_ser #(.WORD_W(WORD_W), .CNT_W(CNT_W), .NWORDS(NWORDS)) ser_i (
    .clk(clk), .rst(rst), .start(ser_start), .ram_rdata(ram_rdata), .raddr(ser_raddr),
    .out_valid(out_valid), .out_bit(out_bit), .out_time(out_time),
    .out_last(out_last), .done(ser_done)
  );

  // R8
  out_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);
endmodule

// File: tb/bit_ptime_engine_tb_top.sv
`timescale 1ns/1ps
module bit_ptime_engine_tb_top;
  localparam int PB = 32, WW = 8, CW = 4, DW_ = 6, AW = 12;
  localparam int NW = PB / WW;
  localparam int SENT = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [CW-1:0] pulse_max = '0;
  logic [DW_-1:0] abort_dly = '0;
  logic [AW-1:0] page_addr = '0;
  logic busy, fl_cmd_valid, out_valid, out_last;
  logic [1:0] fl_cmd;
  logic [AW-1:0] fl_addr;
  logic fl_done = 1'b0, fl_rd_valid = 1'b0;
  logic [WW-1:0] fl_rd_data = '0;
  logic [$clog2(PB)-1:0] out_bit;
  logic [CW-1:0] out_time;

  bit_ptime_engine #(.PAGE_BITS(PB), .WORD_W(WW), .CNT_W(CW), .DLY_W(DW_), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .pulse_max(pulse_max), .abort_dly(abort_dly),
    .page_addr(page_addr), .busy(busy), .fl_cmd_valid(fl_cmd_valid), .fl_cmd(fl_cmd),
    .fl_addr(fl_addr), .fl_done(fl_done), .fl_rd_valid(fl_rd_valid), .fl_rd_data(fl_rd_data),
    .out_valid(out_valid), .out_bit(out_bit), .out_time(out_time), .out_last(out_last)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  longint cyc = 0;
  int thr [PB];
  bit flaky [PB];
  int got [PB];
  int pulses = 0, prog_cnt = 0, erase_cnt = 0, exp_addr = 0, exp_d = 0;
  int beats = 0, last_seen = 0;
  longint prog_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit reads_zero(input int b);
    return (pulses >= thr[b]) && !(flaky[b] && pulses == thr[b] + 1);
  endfunction

  // device model
  initial begin
    @(negedge clk);
    forever begin
      if (!rst && fl_cmd_valid) begin
        chk(fl_addr == exp_addr[AW-1:0], "R2 addr", int'(fl_addr), exp_addr);
        case (fl_cmd)
          2'd0: begin
            erase_cnt++;
            pulses = 0;
            repeat ($urandom_range(1, 4)) @(negedge clk);
            fl_done = 1'b1;
            @(negedge clk);
            fl_done = 1'b0;
          end
          2'd1: begin
            prog_cnt++;
            prog_cyc = cyc;
            @(negedge clk);
          end
          2'd2: begin
            chk(cyc - prog_cyc == longint'(exp_d + 1), "R4 abort gap",
                int'(cyc - prog_cyc), exp_d + 1);
            pulses++;
            repeat ($urandom_range(1, 4)) @(negedge clk);
            fl_done = 1'b1;
            @(negedge clk);
            fl_done = 1'b0;
          end
          default: begin
            repeat ($urandom_range(1, 3)) @(negedge clk);
            for (int w = 0; w < NW; w++) begin
              fl_rd_valid = 1'b1;
              for (int l = 0; l < WW; l++) fl_rd_data[l] = !reads_zero(w * WW + l);
              @(negedge clk);
              fl_rd_valid = 1'b0;
              if ($urandom_range(0, 2) == 0) @(negedge clk);
            end
          end
        endcase
      end else begin
        @(negedge clk);
      end
    end
  end

  // output monitor
  initial forever begin
    @(negedge clk);
    if (!rst && out_valid) begin
      chk(int'(out_bit) == beats, "R8 order", int'(out_bit), beats);
      got[out_bit] = int'(out_time);
      if (out_last) begin
        last_seen++;
        chk(beats == PB - 1, "R8 last", beats, PB - 1);
      end
      beats++;
    end
  end

  task automatic run_case(input int m, input int d, input int addr);
    int me;
    me = (m == SENT) ? SENT - 1 : m;
    prog_cnt = 0; erase_cnt = 0; beats = 0; last_seen = 0;
    exp_addr = addr; exp_d = d;
    for (int i = 0; i < PB; i++) got[i] = -1;
    @(negedge clk);
    pulse_max = CW'(m); abort_dly = DW_'(d); page_addr = AW'(addr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    // R2: second start while busy, different values
    pulse_max = CW'(m + 3); page_addr = AW'(addr + 1); abort_dly = DW_'(d + 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk(erase_cnt == 1, "R2 erase count", erase_cnt, 1);
    if (m == 0) chk(prog_cnt == 0, "R10 no program", prog_cnt, 0);
    else chk(prog_cnt == me, "R6 program count", prog_cnt, me);
    chk(beats == PB, "R8 beats", beats, PB);
    chk(last_seen == 1, "R8 last flag", last_seen, 1);
    for (int i = 0; i < PB; i++) begin
      int e;
      e = (thr[i] <= me) ? thr[i] : SENT;
      if (thr[i] == 0)      chk(got[i] == e, "R3 pre-read zero", got[i], e);
      else if (e == SENT)   chk(got[i] == e, "R7 unflipped", got[i], e);
      else if (flaky[i])    chk(got[i] == e, "R5 frozen", got[i], e);
      else if (m == 0)      chk(got[i] == e, "R10 value", got[i], e);
      else                  chk(got[i] == e, "R9 bit time", got[i], e);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(fl_cmd_valid == 1'b0, "R1 cmd", int'(fl_cmd_valid), 0);
    chk(out_valid == 1'b0, "R1 out", int'(out_valid), 0);
    rst = 1'b0;

    // R10: no pulses
    for (int i = 0; i < PB; i++) begin thr[i] = i % 3; flaky[i] = 1'b0; end
    run_case(0, 2, 12'h155);

    // R5: staggered thresholds with bouncing bits, zero delay
    for (int i = 0; i < PB; i++) begin thr[i] = i % 8; flaky[i] = (i % 5 == 1); end
    run_case(5, 0, 12'h0a3);

    // R6: pulse count clamped at 14
    for (int i = 0; i < PB; i++) begin thr[i] = i % 16; flaky[i] = 1'b0; end
    run_case(SENT, 3, 12'h7ff);

    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < PB; i++) begin
        thr[i] = $urandom_range(0, 15);
        flaky[i] = ($urandom_range(0, 5) == 0);
      end
      run_case($urandom_range(1, 13), $urandom_range(0, 9), $urandom_range(0, 4095));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule